// File: doc/BRIEF.md
# Bit-Serial Real-Time-Clock Bus Master

This block is the host side of a four-wire link to a serial timekeeping device. The wires are an active-low select, an active-low write strobe, an active-low read strobe and a single data line that the block either drives or releases. Every bit crosses the link in a cycle of its own. Select falls, one strobe pulses low, the strobe rises and then select rises. A quiet interval separates one bit cycle from the next.

A client hands over one request at a time through a valid/ready handshake. A request carries a 4-bit address, a data byte and a 2-bit operation code. The block sends the address and then, depending on the operation, sends eight data bits, collects eight read bits, or stops at once. Collected bytes appear on a byte output, and a one-clock done pulse closes every request.

After reset, and before it accepts any request, the block runs a fixed number of throw-away read cycles so that the device sees the start of a fresh transaction. All intervals are counted in system clocks, scaled by a clocks-per-microsecond parameter.

Top module: `rtcb_master`

## Requirements
- R1: After reset is released, the block performs exactly INIT_READS read bit cycles (8 by default) with the data output enable low, and keeps `req_ready` low until they are complete.
- R2: During reset and whenever `req_ready` is high, select, both strobes and `rtc_data_o` are high and `rtc_data_oe` is low.
- R3: Every request begins with four write bit cycles that carry `req_addr`, least significant bit first.
- R4: Operation code 2'b00 (write) sends the four address bits followed by eight write bit cycles carrying `req_data`, least significant bit first, for twelve bit cycles in total.
- R5: Operation codes 2'b10 and 2'b11 (command) end after the four address bit cycles and have no data phase.
- R6: Operation code 2'b01 (read) follows the address with eight read bit cycles. Each sampled bit enters at the top of a right-shifting register, so the first bit received ends in `rd_data[0]`. `rd_data` is updated when the read completes and holds its value through writes and commands.
- R7: In a write bit cycle, select falls while both strobes are high. The write strobe then stays low for CYC_PER_US*STROBE_US clocks with `rtc_data_o` stable, and it rises while select is still low.
- R8: In a read bit cycle, the read strobe stays low for 2*CYC_PER_US*STROBE_US clocks. The data line is sampled at the end of the first half, and both strobes are never low together.
- R9: Between two consecutive bit cycles, select stays high for at least CYC_PER_US*GAP_US+1 clocks.
- R10: `req_ready` falls on the clock after acceptance and stays low until select rises after the last bit cycle. In that first cycle with select high, `done` is high for one clock and `req_ready` is high again.
- R11: `rtc_data_oe` is high only while select is low in a write bit cycle, and never while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 4 | Device address nibble |
| req_data | input | 8 | Byte to write |
| req_op | input | 2 | 00 write, 01 read, 10/11 command |
| rd_data | output | 8 | Byte collected by the last read |
| done | output | 1 | One-clock pulse when a request finishes |
| rtc_cs_n | output | 1 | Device select, active low |
| rtc_wr_n | output | 1 | Write strobe, active low |
| rtc_rd_n | output | 1 | Read strobe, active low |
| rtc_data_o | output | 1 | Value driven onto the data line |
| rtc_data_oe | output | 1 | Data line driver enable |
| rtc_data_i | input | 1 | Value seen on the data line |

## Verification
Completion of one request and acceptance of the next share a clock. In the cycle where `done` pulses, `rd_data` is loaded and `req_ready` is already high, so a queued request is taken on that same edge. The bench keeps `req_valid` ready so that each new request arrives in the done cycle of the previous one. It then checks that the finished read byte is intact and that the new request's address bits follow with a full select-high gap. A model of the device on the pins drives the true bit only in the first half of each read strobe and the inverted bit in the second half, so sampling too late corrupts the returned byte.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

  localparam int ADDR_BITS = 4;
  localparam int DATA_BITS = 8;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'b00,
    OP_READ    = 2'b01,
    OP_CMD     = 2'b10,
    OP_CMD_ALT = 2'b11
  } rtcb_op_e;

  typedef enum logic [2:0] {
    BP_IDLE,
    BP_GAP,
    BP_SEL,
    BP_STB,
    BP_HOLD,
    BP_REL
  } rtcb_phase_e;

  typedef enum logic [2:0] {
    SQ_INIT,
    SQ_IDLE,
    SQ_ADDR,
    SQ_WDAT,
    SQ_RDAT
  } rtcb_seq_e;

endpackage

// File: rtl/rtcb_delay.sv
module rtcb_delay #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rtcb_bitcyc.sv
module rtcb_bitcyc
  import rtcb_pkg::*;
#(
  parameter int STB_CYC = 4,
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_read,
  input  logic wbit,
  input  logic data_i,
  output logic eng_idle,
  output logic bit_done,
  output logic sample_valid,
  output logic sample_bit,
  output logic cs_n,
  output logic wr_n,
  output logic rd_n,
  output logic data_o,
  output logic data_oe
);

  localparam int MAXC = (STB_CYC > GAP_CYC) ? STB_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STB_LD = CW'(STB_CYC - 1);
  localparam logic [CW-1:0] GAP_LD = CW'(GAP_CYC - 1);

  rtcb_phase_e ph_q, ph_d;
  logic        mode_rd_q, bit_q;
  logic        tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic        cap_en;

  rtcb_delay #(.W(CW)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = GAP_LD;
    cap_en   = 1'b0;
    case (ph_q)
      BP_IDLE: if (start) begin
        ph_d     = BP_GAP;
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
        cap_en   = 1'b1;
      end
      BP_GAP: if (tmr_zero) ph_d = BP_SEL;
      BP_SEL: begin
        ph_d     = BP_STB;
        tmr_load = 1'b1;
        tmr_val  = STB_LD;
      end
      BP_STB: if (tmr_zero) begin
        if (mode_rd_q) begin
          ph_d     = BP_HOLD;
          tmr_load = 1'b1;
          tmr_val  = STB_LD;
        end else begin
          ph_d = BP_REL;
        end
      end
      BP_HOLD: if (tmr_zero) ph_d = BP_REL;
      BP_REL:  ph_d = BP_IDLE;
      default: ph_d = BP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= BP_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_rd_q <= 1'b1;
      bit_q     <= 1'b1;
    end else if (cap_en) begin
      mode_rd_q <= is_read;
      bit_q     <= wbit;
    end
  end

  assign eng_idle     = (ph_q == BP_IDLE);
  assign bit_done     = (ph_q == BP_REL);
  assign sample_valid = (ph_q == BP_STB) && tmr_zero && mode_rd_q;
  assign sample_bit   = data_i;
  assign cs_n         = !((ph_q == BP_SEL) || (ph_q == BP_STB) ||
                          (ph_q == BP_HOLD) || (ph_q == BP_REL));
  assign wr_n         = !((ph_q == BP_STB) && !mode_rd_q);
  assign rd_n         = !(((ph_q == BP_STB) || (ph_q == BP_HOLD)) && mode_rd_q);
  assign data_oe      = ((ph_q == BP_SEL) || (ph_q == BP_STB) || (ph_q == BP_REL)) && !mode_rd_q;
  assign data_o       = data_oe ? bit_q : 1'b1;

endmodule

// File: rtl/rtcb_seq.sv
module rtcb_seq
  import rtcb_pkg::*;
#(
  parameter int INIT_READS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic [DATA_BITS-1:0] req_data,
  input  logic [1:0]           req_op,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 done,
  input  logic                 eng_idle,
  input  logic                 bit_done,
  input  logic                 sample_valid,
  input  logic                 sample_bit,
  output logic                 bit_start,
  output logic                 bit_read,
  output logic                 bit_val
);

  localparam int MAXB = (INIT_READS > DATA_BITS) ? INIT_READS : DATA_BITS;
  localparam int IDXW = $clog2(MAXB);
  localparam logic [IDXW-1:0] INIT_LAST = IDXW'(INIT_READS - 1);
  localparam logic [IDXW-1:0] ADDR_LAST = IDXW'(ADDR_BITS - 1);
  localparam logic [IDXW-1:0] DATA_LAST = IDXW'(DATA_BITS - 1);

  rtcb_seq_e             st_q, st_d;
  logic [IDXW-1:0]       idx_q, idx_d;
  logic [ADDR_BITS-1:0]  addr_q;
  logic [DATA_BITS-1:0]  wdat_q, rsh_q, rdat_q;
  rtcb_op_e              op_q;
  logic                  done_q, done_d;
  logic                  accept, capture_rd, shift_en;

  assign accept   = req_valid && (st_q == SQ_IDLE);
  assign shift_en = sample_valid && (st_q == SQ_RDAT);

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    done_d     = 1'b0;
    capture_rd = 1'b0;
    case (st_q)
      SQ_INIT: if (bit_done) begin
        if (idx_q == INIT_LAST) begin
          st_d  = SQ_IDLE;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      SQ_IDLE: if (req_valid) begin
        st_d  = SQ_ADDR;
        idx_d = '0;
      end
      SQ_ADDR: if (bit_done) begin
        if (idx_q == ADDR_LAST) begin
          idx_d = '0;
          case (op_q)
            OP_WRITE: st_d = SQ_WDAT;
            OP_READ:  st_d = SQ_RDAT;
            default: begin
              st_d   = SQ_IDLE;
              done_d = 1'b1;
            end
          endcase
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      SQ_WDAT: if (bit_done) begin
        if (idx_q == DATA_LAST) begin
          st_d   = SQ_IDLE;
          idx_d  = '0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      SQ_RDAT: if (bit_done) begin
        if (idx_q == DATA_LAST) begin
          st_d       = SQ_IDLE;
          idx_d      = '0;
          done_d     = 1'b1;
          capture_rd = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_INIT;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      op_q   <= OP_WRITE;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_data;
      op_q   <= rtcb_op_e'(req_op);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsh_q <= '0;
    else if (shift_en) rsh_q <= {sample_bit, rsh_q[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdat_q <= '0;
    else if (capture_rd) rdat_q <= rsh_q;
  end

  assign req_ready = (st_q == SQ_IDLE);
  assign done      = done_q;
  assign rd_data   = rdat_q;
  assign bit_start = (st_q != SQ_IDLE) && eng_idle;
  assign bit_read  = (st_q == SQ_INIT) || (st_q == SQ_RDAT);
  assign bit_val   = (st_q == SQ_ADDR) ? addr_q[idx_q[1:0]] : wdat_q[idx_q[2:0]];

endmodule

// File: rtl/rtcb_master.sv
module rtcb_master
  import rtcb_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int STROBE_US  = 1,
  parameter int GAP_US     = 1,
  parameter int INIT_READS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [3:0] req_addr,
  input  logic [7:0] req_data,
  input  logic [1:0] req_op,
  output logic [7:0] rd_data,
  output logic       done,
  output logic       rtc_cs_n,
  output logic       rtc_wr_n,
  output logic       rtc_rd_n,
  output logic       rtc_data_o,
  output logic       rtc_data_oe,
  input  logic       rtc_data_i
);

  localparam int STB_CYC = CYC_PER_US * STROBE_US;
  localparam int GAP_CYC = CYC_PER_US * GAP_US;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       eng_idle, bit_done, sample_valid, sample_bit;
  logic       bit_start, bit_read, bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rtcb_seq #(.INIT_READS(INIT_READS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .req_op       (req_op),
    .rd_data      (rd_data),
    .done         (done),
    .eng_idle     (eng_idle),
    .bit_done     (bit_done),
    .sample_valid (sample_valid),
    .sample_bit   (sample_bit),
    .bit_start    (bit_start),
    .bit_read     (bit_read),
    .bit_val      (bit_val)
  );

  rtcb_bitcyc #(.STB_CYC(STB_CYC), .GAP_CYC(GAP_CYC)) u_bit (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start        (bit_start),
    .is_read      (bit_read),
    .wbit         (bit_val),
    .data_i       (rtc_data_i),
    .eng_idle     (eng_idle),
    .bit_done     (bit_done),
    .sample_valid (sample_valid),
    .sample_bit   (sample_bit),
    .cs_n         (rtc_cs_n),
    .wr_n         (rtc_wr_n),
    .rd_n         (rtc_rd_n),
    .data_o       (rtc_data_o),
    .data_oe      (rtc_data_oe)
  );

endmodule

// File: rtl/rtcb_master_chk.sv
module rtcb_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic rtc_cs_n,
  input logic rtc_wr_n,
  input logic rtc_rd_n,
  input logic rtc_data_o,
  input logic rtc_data_oe
);

  // R2
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rtc_cs_n && rtc_wr_n && rtc_rd_n && rtc_data_o && !rtc_data_oe));

  // R7
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtc_wr_n || !rtc_rd_n) |-> !rtc_cs_n);

  // R7
  select_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtc_cs_n) |-> (rtc_wr_n && rtc_rd_n));

  // R7
  write_rise_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_wr_n) |-> !rtc_cs_n);

  // R7
  write_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtc_wr_n && $past(!rtc_wr_n)) |-> $stable(rtc_data_o));

  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_wr_n || rtc_rd_n));

  // R11
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_data_oe |-> (rtc_rd_n && !rtc_cs_n));

  // R10
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && rtc_cs_n));

endmodule

bind rtcb_master rtcb_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .rtc_cs_n    (rtc_cs_n),
  .rtc_wr_n    (rtc_wr_n),
  .rtc_rd_n    (rtc_rd_n),
  .rtc_data_o  (rtc_data_o),
  .rtc_data_oe (rtc_data_oe)
);

// File: tb/rtcb_master_tb.sv
module rtcb_master_tb;

  localparam int CPU   = 4;
  localparam int STB   = CPU;
  localparam int GAP   = CPU;
  localparam int NINIT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid;
  logic       req_ready;
  logic [3:0] req_addr;
  logic [7:0] req_data;
  logic [1:0] req_op;
  logic [7:0] rd_data;
  logic       done;
  logic       cs_n, wr_n, rd_n, data_o, oe;
  logic       rtc_di;

  always #5 clk = ~clk;

  rtcb_master #(.CYC_PER_US(CPU), .STROBE_US(1), .GAP_US(1), .INIT_READS(NINIT)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .req_op      (req_op),
    .rd_data     (rd_data),
    .done        (done),
    .rtc_cs_n    (cs_n),
    .rtc_wr_n    (wr_n),
    .rtc_rd_n    (rd_n),
    .rtc_data_o  (data_o),
    .rtc_data_oe (oe),
    .rtc_data_i  (rtc_di)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin monitor and device model
  int   obs_n = 0;
  logic obs_k [0:31];
  logic obs_v [0:31];
  logic cur_k = 1'b0, cur_v = 1'b0;
  int   wr_len = 0, rd_len = 0, cs_hi = 0, rpos = 0;
  int   v_wr = 0, v_rd = 0, v_gap = 0, v_oe = 0, v_done = 0;
  logic p_cs = 1'b1, p_wr = 1'b1, p_rd = 1'b1;
  logic seen_bit = 1'b0;
  logic [7:0] slave_byte = 8'h00;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_cs = 1'b1; p_wr = 1'b1; p_rd = 1'b1;
      cs_hi = 0; wr_len = 0; rd_len = 0; rtc_di = 1'b1;
    end else begin
      if (!cs_n && p_cs) begin
        if (seen_bit && cs_hi < GAP + 1) v_gap++;
        cs_hi = 0; cur_k = 1'b0; cur_v = 1'b0; seen_bit = 1'b1;
      end
      if (cs_n) cs_hi++;
      if (!wr_n && p_wr) cur_v = data_o;
      if (!wr_n) begin
        wr_len++;
        if (!oe) v_oe++;
      end
      if (wr_n && !p_wr) begin
        if (wr_len != STB) v_wr++;
        wr_len = 0;
      end
      if (!rd_n) begin
        rd_len++;
        cur_k = 1'b1;
        if (oe) v_oe++;
        rtc_di = (rd_len <= STB) ? slave_byte[rpos % 8] : ~slave_byte[rpos % 8];
      end
      if (rd_n && !p_rd) begin
        if (rd_len != 2 * STB) v_rd++;
        rd_len = 0; rpos++; rtc_di = 1'b1;
      end
      if (oe && (cs_n || !rd_n)) v_oe++;
      if (cs_n && !p_cs) begin
        if (obs_n < 32) begin
          obs_k[obs_n] = cur_k;
          obs_v[obs_n] = cur_v;
        end
        obs_n++;
      end
      if (done && !(cs_n && !p_cs && req_ready)) v_done++;
      p_cs = cs_n; p_wr = wr_n; p_rd = rd_n;
    end
  end

  logic [7:0] last_rd = 8'h00;

  task automatic do_txn(input logic [1:0] op, input logic [3:0] a,
                        input logic [7:0] d, input logic [7:0] sb);
    int  exp_n;
    int  n;
    bit  ok;
    bit  rdy_bad;
    n = 0;
    while (!req_ready && n < 3000) begin
      @(negedge clk); #1; n++;
    end
    obs_n = 0; rpos = 0; slave_byte = sb;
    req_valid = 1'b1; req_addr = a; req_data = d; req_op = op;
    @(negedge clk); #1;
    req_valid = 1'b0;
    rdy_bad = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      if (req_ready) rdy_bad = 1'b1;
      @(negedge clk); #1; n++;
    end
    chk(done && !rdy_bad, "R10 ready low until done", {30'd0, rdy_bad, done}, 1);
    exp_n = op[1] ? 4 : 12;
    ok = (obs_n == exp_n);
    for (int i = 0; i < exp_n && i < 32; i++) begin
      logic ek, ev;
      ek = (i >= 4) && (op == 2'b01);
      ev = (i < 4) ? a[i] : d[i - 4];
      if (obs_k[i] !== ek) ok = 1'b0;
      if (!ek && (obs_v[i] !== ev)) ok = 1'b0;
    end
    if (op[1])
      chk(ok, "R5 R3 command has address only", obs_n, exp_n);
    else if (op == 2'b00)
      chk(ok, "R4 R3 write address then data lsb first", obs_n, exp_n);
    else
      chk(ok, "R6 R3 read address then eight read cycles", obs_n, exp_n);
    if (op == 2'b01) begin
      chk(rd_data == sb, "R6 R8 read byte assembled lsb first", rd_data, sb);
      last_rd = sb;
    end else begin
      chk(rd_data == last_rd, "R6 rd_data held", rd_data, last_rd);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int reads;
    int n;
    void'($urandom(32'h1d2c3b4a));
    req_valid = 1'b0; req_addr = '0; req_data = '0; req_op = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n && wr_n && rd_n && data_o && !oe && !req_ready && !done,
        "R2 pins idle in reset", {cs_n, wr_n, rd_n, data_o, oe}, 5'b11110);
    obs_n = 0;
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 3000) begin
      @(negedge clk); #1; n++;
    end
    reads = 0;
    for (int i = 0; i < obs_n && i < 32; i++) if (obs_k[i]) reads++;
    chk(req_ready && obs_n == NINIT && reads == NINIT, "R1 dummy reads before ready", obs_n, NINIT);
    chk(cs_n && wr_n && rd_n && data_o && !oe, "R2 pins idle when ready",
        {cs_n, wr_n, rd_n, data_o, oe}, 5'b11110);

    // directed corner cases
    do_txn(2'b00, 4'h5, 8'hA3, 8'h00);   // R4
    do_txn(2'b01, 4'h5, 8'h00, 8'h01);   // R6 first bit lands in bit 0
    do_txn(2'b01, 4'hA, 8'h00, 8'h80);   // R6 last bit lands in bit 7
    do_txn(2'b10, 4'hE, 8'hFF, 8'h00);   // R5
    do_txn(2'b11, 4'h1, 8'h55, 8'h00);   // R5 alias code
    do_txn(2'b00, 4'hF, 8'hFF, 8'h00);   // R6 hold across write
    do_txn(2'b01, 4'h0, 8'h00, 8'h00);
    do_txn(2'b01, 4'h3, 8'h00, 8'hFF);

    // constrained random
    for (int k = 0; k < 40; k++) begin
      do_txn(2'($urandom_range(0, 3)), 4'($urandom), 8'($urandom), 8'($urandom));
    end

    @(negedge clk); #1;
    chk(cs_n && wr_n && rd_n && !oe && req_ready, "R2 idle after traffic",
        {cs_n, wr_n, rd_n, oe}, 4'b1110);
    chk(v_wr == 0, "R7 write strobe width", v_wr, 0);
    chk(v_rd == 0, "R8 read strobe width", v_rd, 0);
    chk(v_gap == 0, "R9 select gap between bits", v_gap, 0);
    chk(v_oe == 0, "R11 driver enable only in write cycles", v_oe, 0);
    chk(v_done == 0, "R10 done aligned with select rise", v_done, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule